// File: doc/BRIEF.md
# Endpoint-Zero Handshake Register

This block is the 8-bit control and status register for endpoint zero of a full-speed USB device, together with the interrupt-enable register for the device's bus-level events. It connects a CPU bus to the USB transaction engine. The CPU reaches it through an address decode, a write strobe and separate write and read data paths. The transaction engine reports IN-token, host-ACK, SETUP and OUT-packet events. The block answers with a send-or-NAK decision for IN tokens, the IN payload length, and an accept flag for OUT packets.

One CSR address has two meanings. A read returns the length of the last accepted OUT packet in the upper nibble. A write to the upper nibble sets the length of the next IN payload, and that value can only be seen on the `in_len` output. The IN-valid bit is owned by software, and hardware clears it when an IN succeeds or a SETUP arrives. The IN-complete bit is set by hardware and stays set until software writes a zero to it. While it is set, every IN token gets a NAK. The OUT side uses the same pairing: an arm bit that software sets and hardware clears, and a sticky done bit.

Three interrupt sources share one request line: USB reset, resume and suspend. Each source has its own enable bit.

Top module: `ep0_hs_reg`

## Requirements
- R1: A synchronous reset clears every CSR bit, the IN length, the stored OUT length and all three interrupt enables. After reset, `in_ready`, `out_accept` and `irq` are 0.
- R2: Reading address `CSR_ADDR` returns {out length[7:4], in_valid[3], in_done[2], out_armed[1], out_done[0]}. Reading `IEN_ADDR` returns {5'b0, usbrst_en[2], resume_en[1], suspend_en[0]}. Reading any other address returns 0.
- R3: A write to `CSR_ADDR` loads `cpu_wdata[7:4]` into `in_len`, which changes on the next clock. The value written never appears in `cpu_rdata[7:4]`.
- R4: A CSR write sets in_valid when bit 3 is 1 and clears it when bit 3 is 0.
- R5: `in_ready` equals in_valid AND NOT in_done. `in_nak` equals `in_token` AND NOT `in_ready`.
- R6: An `in_ack` while `in_ready` is 1 clears in_valid and sets in_done at the next clock. An `in_ack` while `in_ready` is 0 changes nothing.
- R7: A `setup_ok` clears in_valid at the next clock. When a hardware clear of in_valid and a CPU write of 1 to bit 3 fall in the same cycle, the clear wins.
- R8: Only a CSR write with bit 2 equal to 0 clears in_done. Writing 1 to bit 2 leaves it unchanged. When a hardware set and a clearing write fall in the same cycle, the set wins.
- R9: `out_accept` equals out_armed AND NOT out_done. An `out_ok` while `out_accept` is 1 stores `out_len`, clears out_armed and sets out_done. An `out_ok` while `out_accept` is 0 is ignored. Bit 1 is written like bit 3, and bit 0 is cleared like bit 2.
- R10: The USB-reset source requests an interrupt only when usbrst_en, `usb_rst_flag` and `rst_detect_cfg` are all 1.
- R11: The resume source requests when resume_en and `resume_flag` are both 1, and the suspend source likewise with its own enable and flag. `irq` is the OR of the three requests and depends on the flags combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr` |
| in_token | input | 1 | IN token addressed to endpoint zero |
| in_ack | input | 1 | Host ACK of the IN data just sent |
| setup_ok | input | 1 | Valid SETUP packet received |
| out_ok | input | 1 | Valid OUT packet received |
| out_len | input | 4 | Byte count of that OUT packet |
| usb_rst_flag | input | 1 | USB reset status flag |
| rst_detect_cfg | input | 1 | Reset-detect configuration bit |
| resume_flag | input | 1 | Resume status flag |
| suspend_flag | input | 1 | Suspend status flag |
| in_ready | output | 1 | Send data on the next IN token |
| in_nak | output | 1 | Answer the present IN token with NAK |
| in_len | output | 4 | IN payload byte count |
| out_accept | output | 1 | Next OUT packet may be accepted |
| irq | output | 1 | CPU interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 8, `CSR_ADDR` = 8'h10 and `IEN_ADDR` = 8'h11. With these values an unmapped address such as 8'h33 can be driven, so both the decode and the zero read-back can be exercised. Directed phases place hardware events in the same cycle as the opposing CPU write for both the IN and OUT bit pairs, so every priority rule is tested. They also repeat ACK and OUT events while the block is not ready. A long random phase then drives every input together against the behavioural model.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;

    localparam int LEN_W   = 4;
    localparam int FLAG_W  = 4;
    localparam int REG_W   = LEN_W + FLAG_W;
    localparam int NUM_SRC = 3;

    // Flag bit positions inside the CSR (decoded by software)
    localparam int POS_OUT_DONE = 0;
    localparam int POS_OUT_ARM  = 1;
    localparam int POS_IN_DONE  = 2;
    localparam int POS_IN_VALID = 3;

    typedef enum logic [1:0] {
        SRC_SUSPEND = 2'd0,
        SRC_RESUME  = 2'd1,
        SRC_USBRST  = 2'd2
    } irq_src_e;

    // Field order follows bits 3..0 of the CSR
    typedef struct packed {
        logic in_valid;
        logic in_done;
        logic out_armed;
        logic out_done;
    } ep0_flags_t;

    // Bit owned by software, cleared by hardware; the hardware clear has priority
    function automatic logic owned_next(input logic cur, input logic hw_clr,
                                        input logic wr, input logic wbit);
        logic n;
        n = cur;
        if (wr)     n = wbit;
        if (hw_clr) n = 1'b0;
        return n;
    endfunction

    // Sticky bit set by hardware, cleared only by writing 0; the set has priority
    function automatic logic sticky_next(input logic cur, input logic hw_set,
                                         input logic wr, input logic wbit);
        logic n;
        n = cur;
        if (wr && !wbit) n = 1'b0;
        if (hw_set)      n = 1'b1;
        return n;
    endfunction

    function automatic logic [REG_W-1:0] pack_csr(input logic [LEN_W-1:0] len,
                                                  input ep0_flags_t f);
        return {len, f};
    endfunction

endpackage

// File: rtl/ep0_bus_dec.sv
module ep0_bus_dec #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] IEN_ADDR = 8'h11
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic              csr_sel,
    output logic              ien_sel,
    output logic              csr_wr,
    output logic              ien_wr
);
    always_comb begin
        csr_sel = (cpu_addr == CSR_ADDR);
        ien_sel = (cpu_addr == IEN_ADDR);
        csr_wr  = cpu_wr && csr_sel;
        ien_wr  = cpu_wr && ien_sel;
    end
endmodule

// File: rtl/ep0_in_side.sv
module ep0_in_side
    import ep0_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             wr_valid_bit,
    input  logic             wr_done_bit,
    input  logic             in_token,
    input  logic             in_ack,
    input  logic             setup_ok,
    output logic             in_valid,
    output logic             in_done,
    output logic [LEN_W-1:0] in_len,
    output logic             in_ready,
    output logic             in_nak
);
    logic ack_hit;
    logic valid_clr;

    always_comb begin
        in_ready  = in_valid && !in_done;
        in_nak    = in_token && !in_ready;
        ack_hit   = in_ack && in_ready;
        valid_clr = ack_hit || setup_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_valid <= 1'b0;
            in_done  <= 1'b0;
            in_len   <= '0;
        end else begin
            in_valid <= owned_next(in_valid, valid_clr, csr_wr, wr_valid_bit);
            in_done  <= sticky_next(in_done, ack_hit, csr_wr, wr_done_bit);
            if (csr_wr) in_len <= wr_len;
        end
    end
endmodule

// File: rtl/ep0_out_side.sv
module ep0_out_side
    import ep0_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr,
    input  logic             wr_arm_bit,
    input  logic             wr_done_bit,
    input  logic             out_ok,
    input  logic [LEN_W-1:0] out_len,
    output logic             out_armed,
    output logic             out_done,
    output logic [LEN_W-1:0] rx_len,
    output logic             out_accept
);
    logic rx_hit;

    always_comb begin
        out_accept = out_armed && !out_done;
        rx_hit     = out_ok && out_accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_armed <= 1'b0;
            out_done  <= 1'b0;
            rx_len    <= '0;
        end else begin
            out_armed <= owned_next(out_armed, rx_hit, csr_wr, wr_arm_bit);
            out_done  <= sticky_next(out_done, rx_hit, csr_wr, wr_done_bit);
            if (rx_hit) rx_len <= out_len;
        end
    end
endmodule

// File: rtl/ep0_irq_ctl.sv
module ep0_irq_ctl
    import ep0_hs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ien_wr,
    input  logic [NUM_SRC-1:0] wr_en,
    input  logic               usb_rst_flag,
    input  logic               rst_detect_cfg,
    input  logic               resume_flag,
    input  logic               suspend_flag,
    output logic [NUM_SRC-1:0] ien_q,
    output logic               irq
);
    logic [NUM_SRC-1:0] src_flag;
    logic [NUM_SRC-1:0] src_req;

    always_comb begin
        src_flag = '0;
        src_flag[int'(SRC_SUSPEND)] = suspend_flag;
        src_flag[int'(SRC_RESUME)]  = resume_flag;
        src_flag[int'(SRC_USBRST)]  = usb_rst_flag && rst_detect_cfg;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)         ien_q[s] <= 1'b0;
            else if (ien_wr) ien_q[s] <= wr_en[s];
        end
        assign src_req[s] = ien_q[s] && src_flag[s];
    end

    assign irq = |src_req;
endmodule

// File: rtl/ep0_hs_reg.sv
module ep0_hs_reg
    import ep0_hs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] IEN_ADDR = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              in_token,
    input  logic              in_ack,
    input  logic              setup_ok,
    input  logic              out_ok,
    input  logic [3:0]        out_len,
    input  logic              usb_rst_flag,
    input  logic              rst_detect_cfg,
    input  logic              resume_flag,
    input  logic              suspend_flag,
    output logic              in_ready,
    output logic              in_nak,
    output logic [3:0]        in_len,
    output logic              out_accept,
    output logic              irq
);
    logic csr_sel, ien_sel, csr_wr, ien_wr;
    ep0_flags_t flags;
    logic [LEN_W-1:0]   rx_len;
    logic [NUM_SRC-1:0] ien_q;
    logic in_done_w;

    ep0_bus_dec #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .IEN_ADDR(IEN_ADDR)) dec_i (
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .csr_sel(csr_sel), .ien_sel(ien_sel), .csr_wr(csr_wr), .ien_wr(ien_wr)
    );

    ep0_in_side in_i (
        .clk(clk), .rst(rst), .csr_wr(csr_wr),
        .wr_len(cpu_wdata[REG_W-1:FLAG_W]),
        .wr_valid_bit(cpu_wdata[POS_IN_VALID]),
        .wr_done_bit(cpu_wdata[POS_IN_DONE]),
        .in_token(in_token), .in_ack(in_ack), .setup_ok(setup_ok),
        .in_valid(flags.in_valid), .in_done(in_done_w), .in_len(in_len),
        .in_ready(in_ready), .in_nak(in_nak)
    );
    assign flags.in_done = in_done_w;

    ep0_out_side out_i (
        .clk(clk), .rst(rst), .csr_wr(csr_wr),
        .wr_arm_bit(cpu_wdata[POS_OUT_ARM]),
        .wr_done_bit(cpu_wdata[POS_OUT_DONE]),
        .out_ok(out_ok), .out_len(out_len),
        .out_armed(flags.out_armed), .out_done(flags.out_done),
        .rx_len(rx_len), .out_accept(out_accept)
    );

    ep0_irq_ctl irq_i (
        .clk(clk), .rst(rst), .ien_wr(ien_wr),
        .wr_en(cpu_wdata[NUM_SRC-1:0]),
        .usb_rst_flag(usb_rst_flag), .rst_detect_cfg(rst_detect_cfg),
        .resume_flag(resume_flag), .suspend_flag(suspend_flag),
        .ien_q(ien_q), .irq(irq)
    );

    always_comb begin
        cpu_rdata = '0;
        if (csr_sel)      cpu_rdata = pack_csr(rx_len, flags);
        else if (ien_sel) cpu_rdata[NUM_SRC-1:0] = ien_q;
    end
endmodule

// File: rtl/ep0_hs_chk.sv
module ep0_hs_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [3:0]        wr_len,
    input logic              wr_done_bit,
    input logic              in_ack,
    input logic              setup_ok,
    input logic              out_ok,
    input logic              usb_rst_flag,
    input logic              rst_detect_cfg,
    input logic              resume_flag,
    input logic              suspend_flag,
    input logic              in_ready,
    input logic [3:0]        in_len,
    input logic              out_accept,
    input logic              irq,
    input logic              in_done
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!in_ready && !out_accept && in_len == 4'd0));

    // R3
    in_len_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == CSR_ADDR) |=> (in_len == $past(wr_len)));

    // R6
    ack_ends_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ack && in_ready) |=> (!in_ready && in_done));

    // R7
    setup_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        setup_ok |=> !in_ready);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (in_done && !(cpu_wr && cpu_addr == CSR_ADDR && !wr_done_bit)) |=> in_done);

    // R9
    out_once_chk: assert property (@(posedge clk) disable iff (rst)
        (out_ok && out_accept) |=> !out_accept);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!resume_flag && !suspend_flag && !(usb_rst_flag && rst_detect_cfg)) |-> !irq);
endmodule

bind ep0_hs_reg ep0_hs_chk #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) chk_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .wr_len(cpu_wdata[7:4]), .wr_done_bit(cpu_wdata[2]),
    .in_ack(in_ack), .setup_ok(setup_ok), .out_ok(out_ok),
    .usb_rst_flag(usb_rst_flag), .rst_detect_cfg(rst_detect_cfg),
    .resume_flag(resume_flag), .suspend_flag(suspend_flag),
    .in_ready(in_ready), .in_len(in_len), .out_accept(out_accept),
    .irq(irq), .in_done(in_done_w)
);

// File: tb/ep0_hs_reg_tb.sv
`timescale 1ns/1ps
module ep0_hs_reg_tb_top;
    localparam logic [7:0] CSR_A = 8'h10;
    localparam logic [7:0] IEN_A = 8'h11;
    localparam logic [7:0] BAD_A = 8'h33;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] cpu_addr = '0;
    logic cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic in_token = 0, in_ack = 0, setup_ok = 0, out_ok = 0;
    logic [3:0] out_len = '0;
    logic usb_rst_flag = 0, rst_detect_cfg = 0, resume_flag = 0, suspend_flag = 0;
    logic in_ready, in_nak, out_accept, irq;
    logic [3:0] in_len;

    always #2.5 clk = ~clk;

    ep0_hs_reg #(.ADDR_W(8), .CSR_ADDR(CSR_A), .IEN_ADDR(IEN_A)) dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .in_token(in_token),
        .in_ack(in_ack), .setup_ok(setup_ok), .out_ok(out_ok), .out_len(out_len),
        .usb_rst_flag(usb_rst_flag), .rst_detect_cfg(rst_detect_cfg),
        .resume_flag(resume_flag), .suspend_flag(suspend_flag),
        .in_ready(in_ready), .in_nak(in_nak), .in_len(in_len),
        .out_accept(out_accept), .irq(irq)
    );

    // Behavioural reference state
    int m_iv, m_id, m_il, m_oa, m_od, m_ol, m_en;
    int n_cmp = 0, n_bad = 0;
    bit started = 0;
    string phase = "R1";

    always @(posedge clk) begin
        bit cw, iw, rdy, acc;
        started = 1;
        if (rst) begin
            m_iv = 0; m_id = 0; m_il = 0; m_oa = 0; m_od = 0; m_ol = 0; m_en = 0;
        end else begin
            cw  = cpu_wr && cpu_addr == CSR_A;
            iw  = cpu_wr && cpu_addr == IEN_A;
            rdy = m_iv == 1 && m_id == 0;
            acc = m_oa == 1 && m_od == 0;
            if (cw) begin
                m_il = cpu_wdata / 16;
                m_iv = cpu_wdata[3];
                m_oa = cpu_wdata[1];
                if (!cpu_wdata[2]) m_id = 0;
                if (!cpu_wdata[0]) m_od = 0;
            end
            if (iw) m_en = cpu_wdata % 8;
            if (in_ack && rdy) begin m_iv = 0; m_id = 1; end
            if (setup_ok) m_iv = 0;
            if (out_ok && acc) begin m_oa = 0; m_od = 1; m_ol = out_len; end
        end
    end

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s act=%0h exp=%0h t=%0t", phase, tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int rdy, exp_rd, exp_irq;
        if (started) begin
            rdy = (m_iv == 1 && m_id == 0) ? 1 : 0;
            if (cpu_addr == CSR_A)      exp_rd = m_ol * 16 + m_iv * 8 + m_id * 4 + m_oa * 2 + m_od;
            else if (cpu_addr == IEN_A) exp_rd = m_en;
            else                        exp_rd = 0;
            exp_irq = 0;
            if ((m_en & 4) != 0 && usb_rst_flag && rst_detect_cfg) exp_irq = 1;
            if ((m_en & 2) != 0 && resume_flag)  exp_irq = 1;
            if ((m_en & 1) != 0 && suspend_flag) exp_irq = 1;
            cmp("R5 in_ready", in_ready, rdy);
            cmp("R5 in_nak", in_nak, (in_token && rdy == 0) ? 1 : 0);
            cmp("R3 in_len", in_len, m_il);
            cmp("R9 out_accept", out_accept, (m_oa == 1 && m_od == 0) ? 1 : 0);
            cmp("R2 rdata", cpu_rdata, exp_rd);
            cmp("R11 irq", irq, exp_irq);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cpu_addr = a; cpu_wr = 1; cpu_wdata = d;
        step();
        cpu_wr = 0; cpu_addr = CSR_A;
    endtask

    task automatic pulse_clear();
        in_ack = 0; setup_ok = 0; out_ok = 0; cpu_wr = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        phase = "R1"; rst = 0; cpu_addr = CSR_A; step();
        phase = "R2"; cpu_addr = IEN_A; step(); cpu_addr = BAD_A; step(); cpu_addr = CSR_A;

        phase = "R3"; wr(CSR_A, 8'hA0); step();
        phase = "R4"; wr(CSR_A, 8'h58); step(); wr(CSR_A, 8'h50); step(); wr(CSR_A, 8'h58);
        phase = "R5"; in_token = 1; step(); in_token = 0;
        phase = "R6"; in_ack = 1; step(); in_ack = 0; in_token = 1; step();
        in_ack = 1; step(); in_ack = 0; in_token = 0;
        phase = "R8"; wr(CSR_A, 8'h5C); in_token = 1; step(); in_token = 0;
        wr(CSR_A, 8'h58); step();
        in_ack = 1; cpu_addr = CSR_A; cpu_wr = 1; cpu_wdata = 8'h38; step(); pulse_clear(); step();
        wr(CSR_A, 8'h38);
        phase = "R7"; setup_ok = 1; step(); setup_ok = 0; wr(CSR_A, 8'h48);
        setup_ok = 1; cpu_addr = CSR_A; cpu_wr = 1; cpu_wdata = 8'h48; step(); pulse_clear(); step();

        phase = "R9"; wr(CSR_A, 8'h02);
        out_ok = 1; out_len = 4'd7; step(); out_ok = 0; step();
        out_ok = 1; out_len = 4'd3; step(); out_ok = 0;
        wr(CSR_A, 8'h03); step(); wr(CSR_A, 8'h02);
        out_ok = 1; out_len = 4'd12; cpu_addr = CSR_A; cpu_wr = 1; cpu_wdata = 8'h02; step();
        pulse_clear(); step();

        phase = "R10"; wr(IEN_A, 8'h04); cpu_addr = IEN_A;
        usb_rst_flag = 1; step(); rst_detect_cfg = 1; step(); usb_rst_flag = 0; step();
        phase = "R11"; wr(IEN_A, 8'h03); resume_flag = 1; step(); resume_flag = 0;
        suspend_flag = 1; step(); wr(IEN_A, 8'h01); step(); wr(IEN_A, 8'h00); step();
        suspend_flag = 0;

        phase = "R2";
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 2))
                0: cpu_addr = CSR_A;
                1: cpu_addr = IEN_A;
                default: cpu_addr = BAD_A;
            endcase
            cpu_wr = ($urandom_range(0, 3) == 0);
            cpu_wdata = 8'($urandom_range(0, 255));
            in_token = 1'($urandom_range(0, 1));
            in_ack = 1'($urandom_range(0, 1));
            setup_ok = ($urandom_range(0, 5) == 0);
            out_ok = 1'($urandom_range(0, 1));
            out_len = 4'($urandom_range(0, 15));
            usb_rst_flag = 1'($urandom_range(0, 1));
            rst_detect_cfg = 1'($urandom_range(0, 1));
            resume_flag = 1'($urandom_range(0, 1));
            suspend_flag = 1'($urandom_range(0, 1));
            step();
        end
        pulse_clear();
        phase = "R1"; rst = 1; step(); rst = 0; cpu_addr = CSR_A; step(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule